// File: doc/BRIEF.md
# Folded Two-Dimensional Shuffle and Butterfly Permuter

This block reorders a vector of sixteen data words, each produced by one element of a 4x4 grid of processing elements, according to either a perfect-shuffle or a butterfly permutation of a selectable order k. A word's grid position is given by a 4-bit index: bits [1:0] select the row and bits [3:2] select the column, so column c holds indices 4c to 4c+3 from top to bottom. The word entering at index i leaves at the index obtained by remapping the bits of i.

Instead of a flat 16-way crossbar, the permutation is folded onto the grid and built from three registered sub-stages, each of which can permute only within rows, only within columns, or swap the lowest row bit with the lowest column bit (the link step). For orders up to 2 only a row step is needed. For larger orders the shuffle runs a row shuffle, then a column shuffle, then the link step, while the butterfly runs a column butterfly, the link step and the same column butterfly again. Mode and order travel with each vector, so a new vector with any setting may enter on every clock.

Top module: `fold_perm2d`

## Requirements
- R1: Every vector presented with in_valid high appears on out_data with out_valid high exactly three clock cycles later, and a cycle with in_valid low yields out_valid low three cycles later; one vector per cycle is accepted with no stalls.
- R2: While rst_n is low, and for the first three cycles after it rises, out_valid is low; asserting rst_n low with vectors in flight drops them.
- R3: With in_bfly = 0 (shuffle) and order k in 2..4, the word at input index i appears at output index j, where j is i with its low k bits rotated left by one place (bit k-1 of j takes bit k-2 of i, and so on, while bit 0 of j takes bit k-1 of i); bits above k are unchanged.
- R4: With in_bfly = 1 (butterfly) and order k in 2..4, the word at input index i appears at output index j, where j is i with bit k-1 and bit 0 exchanged and all other bits unchanged.
- R5: Order k = 1 leaves every word in place in both modes.
- R6: Order values 0 and 5 to 7 leave every word in place in both modes.
- R7: Mode and order are taken per vector; changing them on every cycle gives each vector its own permutation, unaffected by its neighbours.
- R8: With order k of 1 or 2, every word stays in its own column (index bits [3:2] unchanged).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector valid |
| in_data | input | 128 | Sixteen 8-bit words, word i at bits [8i+7:8i] |
| in_bfly | input | 1 | Permutation select: 0 shuffle, 1 butterfly |
| in_order | input | 3 | Permutation order k |
| out_valid | output | 1 | Output vector valid |
| out_data | output | 128 | Permuted words, word j at bits [8j+7:8j] |

## Verification
Each vector's result is due on the third rising edge after the edge that accepts it, so the bench drives and samples on falling edges and keeps a queue of expected vectors that is exactly three entries deep; on every falling edge the head is popped and compared with out_valid and out_data before the next vector is pushed. Until three entries have accumulated after a reset, the only expected output is a low out_valid, which covers both the reset state and a reset applied with vectors still in the pipeline. Expected index remaps are computed from the bit formulas of the requirements, not from the row, column and link split.

// File: rtl/fold_perm_pkg.sv
package fold_perm_pkg;

   // Operation applied by one folded sub-stage
   typedef enum logic [2:0] {
      OP_PASS    = 3'd0,
      OP_ROW_SHF = 3'd1,
      OP_ROW_BFY = 3'd2,
      OP_COL_SHF = 3'd3,
      OP_COL_BFY = 3'd4,
      OP_LINK    = 3'd5
   } fold_op_e;

   // Rotate the len-bit field of v starting at bit lo left by one place
   function automatic int rot_field(input int v, input int lo, input int len);
      int m;
      int f;
      if (len <= 1) return v;
      m = ((1 << len) - 1) << lo;
      f = (v & m) >> lo;
      f = ((f << 1) | (f >> (len - 1))) & ((1 << len) - 1);
      return (v & ~m) | (f << lo);
   endfunction

   // Exchange bits a and b of v
   function automatic int swap_bits(input int v, input int a, input int b);
      int ba;
      int bb;
      int r;
      ba = (v >> a) & 1;
      bb = (v >> b) & 1;
      r  = v & ~((1 << a) | (1 << b));
      return r | (bb << a) | (ba << b);
   endfunction

   // Destination index of source index idx; h is the number of row bits
   function automatic int fold_dest(input fold_op_e op, input int ord,
                                    input int idx, input int h);
      case (op)
         OP_ROW_SHF: return rot_field(idx, 0, ord);
         OP_ROW_BFY: return swap_bits(idx, 0, ord - 1);
         OP_COL_SHF: return rot_field(idx, h, ord);
         OP_COL_BFY: return swap_bits(idx, h, h + ord - 1);
         OP_LINK:    return swap_bits(idx, 0, h);
         default:    return idx;
      endcase
   endfunction

endpackage

// File: rtl/fold_stage_dec.sv
module fold_stage_dec
   import fold_perm_pkg::*;
#(
   parameter int STAGE = 0,
   parameter int H     = 2,
   parameter int ORD_W = 3
) (
   input  logic             bfly,
   input  logic [ORD_W-1:0] order,
   output fold_op_e         op,
   output logic [ORD_W-1:0] op_ord
);

   localparam int N = 2 * H;

   logic k_ok;
   logic k_row;
   logic [ORD_W-1:0] k_col;

   assign k_ok  = (int'(order) >= 1) && (int'(order) <= N);
   assign k_row = (int'(order) <= H);
   assign k_col = order - ORD_W'(H);

   generate
      if (STAGE == 0) begin : g_first
         always_comb begin
            op     = OP_PASS;
            op_ord = '0;
            if (k_ok) begin
               if (k_row) begin
                  op     = bfly ? OP_ROW_BFY : OP_ROW_SHF;
                  op_ord = order;
               end else if (!bfly) begin
                  op     = OP_ROW_SHF;
                  op_ord = ORD_W'(H);
               end else begin
                  op     = OP_COL_BFY;
                  op_ord = k_col;
               end
            end
         end
      end else if (STAGE == 1) begin : g_middle
         always_comb begin
            op     = OP_PASS;
            op_ord = '0;
            if (k_ok && !k_row) begin
               if (!bfly) begin
                  op     = OP_COL_SHF;
                  op_ord = k_col;
               end else begin
                  op     = OP_LINK;
               end
            end
         end
      end else begin : g_last
         always_comb begin
            op     = OP_PASS;
            op_ord = '0;
            if (k_ok && !k_row) begin
               if (!bfly) begin
                  op     = OP_LINK;
               end else begin
                  op     = OP_COL_BFY;
                  op_ord = k_col;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fold_substage.sv
module fold_substage
   import fold_perm_pkg::*;
#(
   parameter int STAGE = 0,
   parameter int H     = 2,
   parameter int W     = 8,
   parameter int ORD_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [(W<<(2*H))-1:0] in_data,
   input  logic               in_bfly,
   input  logic [ORD_W-1:0]   in_ord,
   output logic               out_vld,
   output logic [(W<<(2*H))-1:0] out_data,
   output logic               out_bfly,
   output logic [ORD_W-1:0]   out_ord
);

   localparam int ELEMS = 1 << (2 * H);
   localparam int DW    = W * ELEMS;

   fold_op_e         op;
   logic [ORD_W-1:0] op_ord;
   logic [DW-1:0]    nxt;

   fold_stage_dec #(
      .STAGE (STAGE),
      .H     (H),
      .ORD_W (ORD_W)
   ) u_dec (
      .bfly   (in_bfly),
      .order  (in_ord),
      .op     (op),
      .op_ord (op_ord)
   );

   // Scatter every source word to its destination slot
   always_comb begin
      nxt = '0;
      for (int i = 0; i < ELEMS; i++) begin
         nxt[fold_dest(op, int'(op_ord), i, H)*W +: W] = in_data[i*W +: W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   always_ff @(posedge clk) begin
      out_data <= nxt;
      out_bfly <= in_bfly;
      out_ord  <= in_ord;
   end

   function automatic logic [W-1:0] xor_words(input logic [DW-1:0] v);
      logic [W-1:0] acc;
      acc = '0;
      for (int i = 0; i < ELEMS; i++) acc ^= v[i*W +: W];
      return acc;
   endfunction

   // R3 R4: a permutation keeps the set of words, so their XOR is preserved
   // R4
   word_xor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (xor_words(out_data) == $past(xor_words(in_data))));

   // R6
   pass_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op == OP_PASS) |=> (out_data == $past(in_data)));

   // R8
   row_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && int'(in_ord) <= H) |->
         !(op inside {OP_COL_SHF, OP_COL_BFY, OP_LINK}));

endmodule

// File: rtl/fold_perm2d.sv
module fold_perm2d
   import fold_perm_pkg::*;
#(
   parameter  int H      = 2,
   parameter  int W      = 8,
   localparam int IDX_W  = 2 * H,
   localparam int ELEMS  = 1 << IDX_W,
   localparam int DW     = W * ELEMS,
   localparam int ORD_W  = $clog2(IDX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   input  logic             in_bfly,
   input  logic [ORD_W-1:0] in_order,
   output logic             out_valid,
   output logic [DW-1:0]    out_data
);

   localparam int NSTG = 3;

   if (H < 1 || H > 3) begin : g_bad_h
      $error("fold_perm2d: H must lie in 1..3");
   end
   if (W < 1) begin : g_bad_w
      $error("fold_perm2d: W must be at least 1");
   end

   logic             v_s [NSTG+1];
   logic [DW-1:0]    d_s [NSTG+1];
   logic             b_s [NSTG+1];
   logic [ORD_W-1:0] k_s [NSTG+1];

   assign v_s[0] = in_valid;
   assign d_s[0] = in_data;
   assign b_s[0] = in_bfly;
   assign k_s[0] = in_order;

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      fold_substage #(
         .STAGE (g),
         .H     (H),
         .W     (W),
         .ORD_W (ORD_W)
      ) u_stg (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_vld   (v_s[g]),
         .in_data  (d_s[g]),
         .in_bfly  (b_s[g]),
         .in_ord   (k_s[g]),
         .out_vld  (v_s[g+1]),
         .out_data (d_s[g+1]),
         .out_bfly (b_s[g+1]),
         .out_ord  (k_s[g+1])
      );
   end

   assign out_valid = v_s[NSTG];
   assign out_data  = d_s[NSTG];

   // R1
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 out_valid);

   // R1
   idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !out_valid);

   // R6
   bad_order_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (int'(in_order) == 0 || int'(in_order) > IDX_W)) |->
         ##3 (out_data == $past(in_data, 3)));

endmodule

// File: tb/sim_fold_perm2d.sv
`timescale 1ns/1ps
module sim_fold_perm2d;

   localparam int W  = 8;
   localparam int E  = 16;
   localparam int DW = W * E;

   typedef struct {
      bit            v;
      logic [DW-1:0] d;
      string         tag;
      int            k;
      bit            idx;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [DW-1:0] in_data;
   logic          in_bfly;
   logic [2:0]    in_order;
   logic          out_valid;
   logic [DW-1:0] out_data;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   fold_perm2d u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_bfly   (in_bfly),
      .in_order  (in_order),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // Destination of index i from the bit formulas of R3..R6
   function automatic int ref_dest(input bit b, input int k, input int i);
      bit src [1:4];
      bit dst [1:4];
      int r;
      if (k < 1 || k > 4) return i;
      for (int j = 1; j <= 4; j++) src[j] = bit'((i >> (j - 1)) & 1);
      dst = src;
      if (!b) begin
         for (int j = 2; j <= k; j++) dst[j] = src[j-1];
         dst[1] = src[k];
      end else begin
         dst[1] = src[k];
         dst[k] = src[1];
      end
      r = 0;
      for (int j = 1; j <= 4; j++) r += int'(dst[j]) << (j - 1);
      return r;
   endfunction

   task automatic check_out();
      exp_t e;
      if (q.size() == 3) begin
         e = q.pop_front();
         n_chk++;
         if (out_valid !== e.v) begin
            n_bad++;
            $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, e.v);
         end
         if (e.v) begin
            n_chk++;
            if (out_data !== e.d) begin
               n_bad++;
               $display("FAIL %s k=%0d out_data actual %h expected %h",
                        e.tag, e.k, out_data, e.d);
            end
            if (e.idx && e.k >= 1 && e.k <= 2) begin
               n_chk++;
               for (int p = 0; p < E; p++) begin
                  if (out_data[p*W+2 +: 2] !== 2'(p >> 2)) begin
                     n_bad++;
                     $display("FAIL R8 slot %0d column actual %0d expected %0d",
                              p, out_data[p*W+2 +: 2], p >> 2);
                     break;
                  end
               end
            end
         end
      end else begin
         n_chk++;
         if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 out_valid actual %0b expected 0", out_valid);
         end
      end
   endtask

   task automatic step(input bit v, input bit b, input int k, input bit idx,
                       input bit alt);
      exp_t e;
      logic [DW-1:0] dat;
      @(negedge clk);
      check_out();
      for (int i = 0; i < E; i++)
         dat[i*W +: W] = idx ? W'(i) : W'($urandom);
      in_valid = v;
      in_bfly  = b;
      in_order = 3'(k);
      in_data  = dat;
      e.v   = v;
      e.k   = k;
      e.idx = idx;
      e.d   = '0;
      for (int i = 0; i < E; i++) e.d[ref_dest(b, k, i)*W +: W] = dat[i*W +: W];
      if (alt)                 e.tag = "R7";
      else if (k == 1)         e.tag = "R5";
      else if (k < 1 || k > 4) e.tag = "R6";
      else if (b)              e.tag = "R4";
      else                     e.tag = "R3";
      q.push_back(e);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_bfly  = 1'b0;
      in_order = '0;
      in_data  = '0;
      repeat (3) begin
         @(negedge clk);
         n_chk++;
         if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 out_valid in reset actual %0b expected 0", out_valid);
         end
      end
      rst_n = 1'b1;

      // every mode and order with index-valued words (R3 R4 R5 R6 R8)
      for (int b = 0; b < 2; b++)
         for (int k = 0; k < 8; k++) step(1'b1, bit'(b), k, 1'b1, 1'b0);

      // back-to-back changes of mode and order (R7)
      for (int n = 0; n < 40; n++) step(1'b1, bit'(n & 1), (n * 3) % 8, 1'b0, 1'b1);

      // random traffic with gaps (R1 R3 R4)
      for (int n = 0; n < 300; n++)
         step(($urandom % 10) < 7, bit'($urandom % 2), int'($urandom % 8),
              bit'($urandom % 4 == 0), 1'b0);

      // reset with vectors in flight (R2)
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      q.delete();
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R2 out_valid after mid-run reset actual %0b expected 0",
                  out_valid);
      end
      rst_n = 1'b1;
      for (int n = 0; n < 20; n++) step(1'b1, bit'(n % 2), 4 - (n % 4), 1'b0, 1'b0);
      repeat (4) step(1'b0, 1'b0, 0, 1'b0, 1'b0);
      finish_run();
   end

endmodule